// File: doc/BRIEF.md
# Flash Status Polling Controller

This block is the host-side engine that watches an embedded flash operation finish. After the host has written a program or sector-erase command to the flash, a `start` pulse hands the controller the kind of operation, the value the written data bit should take once it is finished, and the address to poll. The controller then reads the flash status byte again and again through a request/acknowledge read port. It compares each pair of consecutive reads and reports the result with a single-cycle `done`, `fail` or `susp` pulse. When the operation has run past its internal limit, the controller first asks for a reset command on its command port.

For sector erase, the host can also queue extra sectors before polling starts. Each `add_req` makes the controller read the status, issue the add-sector command, and read the status again. A raised erase-window bit on either read means the command may not have been accepted, and this is reported with a `win_miss` pulse. While it polls an erase, the controller also flags whether the polled address lies in a sector that is being erased.

States: IDLE, READ1, READ2, COMPARE, RECHECK, RESET_REQ, DONE, FAIL, SUSP, WIN_PRE, WIN_CMD, WIN_POST, WIN_MISS. Transitions:
- IDLE to READ1 on `start`, or IDLE to WIN_PRE on `add_req`.
- READ1 to READ2, and READ2 to COMPARE, each on an acknowledged read.
- COMPARE to READ1 (still busy), RECHECK (limit seen), SUSP, or DONE.
- RECHECK to RESET_REQ or DONE after its second read.
- RESET_REQ to FAIL on `cmd_ack`.
- WIN_PRE to WIN_CMD or WIN_MISS, WIN_CMD to WIN_POST, and WIN_POST to IDLE or WIN_MISS.
- DONE, FAIL, SUSP and WIN_MISS return to IDLE after one cycle.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A read holds `rd_req` high with `rd_addr` stable at the latched address until the cycle in which `rd_ack` is high. `rd_data` is taken in that cycle, and each acknowledged cycle consumes exactly one read.
- R2: After reset, `busy`, `rd_req`, `cmd_req`, `done`, `fail`, `susp`, `win_miss` and `sec_hit` are all 0.
- R3: `busy` is 1 from the cycle after an accepted `start` or `add_req` until the cycle in which a result pulse is high. `done`, `fail`, `susp` and `win_miss` are each high for exactly one cycle, and at most one of them is high at a time.
- R4: Status reads are taken in pairs. If bit 6 differs between the two reads, a new pair is read. If bit 6 is equal and bit 7 of the second read equals `exp_bit`, `done` pulses. If bit 6 is equal and bit 7 differs from `exp_bit`, a new pair is read.
- R5: When bit 6 differs within a pair and bit 5 of the second read is 1, two more reads follow. If bit 6 differs between these two reads, a command with `cmd_code`=1 (reset) is requested at the polled address, and `fail` pulses in the cycle after `cmd_ack`. If bit 6 is equal, `done` pulses and no command is requested.
- R6: For an erase (`op_erase`=1), a pair with equal bit 6 but differing bit 2 gives a `susp` pulse, and this takes precedence over the bit 7 test. For a program, bit 2 is ignored.
- R7: For an erase, a pair in which both bit 6 and bit 2 differ sets `sec_hit`. It then stays set until the next accepted `start`. For a program, `sec_hit` stays 0.
- R8: `add_req` in IDLE reads the status once. If bit 3 of that read is 1, `win_miss` pulses and no command is issued. Otherwise the controller requests `cmd_code`=0 (add sector) at `add_addr`, reads the status again after `cmd_ack`, and pulses `win_miss` if bit 3 of that read is 1. If it is 0, the controller returns to idle with no pulse.
- R9: When `start` and `add_req` arrive together in IDLE, `start` wins. Both are ignored while the controller is busy, and so is any change of `poll_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch polling (taken in IDLE) |
| op_erase | input | 1 | 1 = sector erase, 0 = program |
| exp_bit | input | 1 | Value bit 7 shows when the operation is finished |
| poll_addr | input | AW | Address to poll |
| add_req | input | 1 | Issue one additional sector-erase command |
| add_addr | input | AW | Sector address for the additional command |
| rd_req | output | 1 | Status read request |
| rd_addr | output | AW | Status read address |
| rd_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data | input | DW | Status byte |
| cmd_req | output | 1 | Command request |
| cmd_code | output | 1 | 0 = add sector, 1 = reset |
| cmd_addr | output | AW | Command address |
| cmd_ack | input | 1 | Command acknowledge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| fail | output | 1 | Failure pulse (after reset command) |
| susp | output | 1 | Erase-suspended-read pulse |
| win_miss | output | 1 | Additional sector command possibly not accepted |
| sec_hit | output | 1 | Polled address lies in a sector being erased |

## Verification
A wrong state in this controller shows up at the ports within a read or two. A misrouted COMPARE decision ends the operation with the wrong pulse, or with the right pulse after the wrong number of acknowledged reads. For that reason every sweep point checks both the pulse kind and the exact count of consumed reads. A RECHECK or window path that goes astray shows up as a missing or extra command, or as a wrong `cmd_code`. A stale latch shows up as a wrong `rd_addr` on the very next read request.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_READ1, ST_READ2, ST_COMPARE, ST_RECHECK, ST_RESET_REQ,
        ST_DONE, ST_FAIL, ST_SUSP, ST_WIN_PRE, ST_WIN_CMD, ST_WIN_POST, ST_WIN_MISS
    } fpc_state_e;

    // status byte bit positions (decoded by the flash side, so fixed)
    localparam int unsigned POS_DATA   = 7;
    localparam int unsigned POS_TOGGLE = 6;
    localparam int unsigned POS_LIMIT  = 5;
    localparam int unsigned POS_WINDOW = 3;
    localparam int unsigned POS_ALT    = 2;

    localparam logic CMD_ADD   = 1'b0;
    localparam logic CMD_RESET = 1'b1;
endpackage

// File: rtl/fpc_reader.sv
module fpc_reader #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic          got,
    output logic [DW-1:0] prev,
    output logic [DW-1:0] curr
);
    assign rd_req = go;
    assign got    = go & rd_ack;

    // two-deep history of acknowledged status bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
            curr <= '0;
        end else if (got) begin
            prev <= curr;
            curr <= rd_data;
        end
    end
endmodule

// File: rtl/fpc_classify.sv
module fpc_classify #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] prev,
    input  logic [DW-1:0] curr,
    output logic          tog_main,
    output logic          tog_alt,
    output logic          limit_hit,
    output logic          data_bit
);
    import fpc_pkg::*;

    always_comb begin
        tog_main  = prev[POS_TOGGLE] ^ curr[POS_TOGGLE];
        tog_alt   = prev[POS_ALT] ^ curr[POS_ALT];
        limit_hit = curr[POS_LIMIT];
        data_bit  = curr[POS_DATA];
    end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_erase,
    input  logic          exp_bit,
    input  logic [AW-1:0] poll_addr,
    input  logic          add_req,
    input  logic [AW-1:0] add_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          cmd_req,
    output logic          cmd_code,
    output logic [AW-1:0] cmd_addr,
    input  logic          cmd_ack,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          susp,
    output logic          win_miss,
    output logic          sec_hit
);
    import fpc_pkg::*;

    fpc_state_e    state_q, state_d;
    logic          op_q, exp_q, rc_q, sec_q;
    logic [AW-1:0] addr_q;
    logic          rd_go, got;
    logic [DW-1:0] prev, curr;
    logic          tog_main, tog_alt, limit_hit, data_bit;

    fpc_reader #(.DW(DW)) u_reader (
        .clk(clk), .rst_n(rst_n), .go(rd_go), .rd_ack(rd_ack), .rd_data(rd_data),
        .rd_req(rd_req), .got(got), .prev(prev), .curr(curr)
    );

    fpc_classify #(.DW(DW)) u_classify (
        .prev(prev), .curr(curr), .tog_main(tog_main), .tog_alt(tog_alt),
        .limit_hit(limit_hit), .data_bit(data_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)        state_d = ST_READ1;
                else if (add_req) state_d = ST_WIN_PRE;
            end
            ST_READ1: if (got) state_d = ST_READ2;
            ST_READ2: if (got) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (tog_main)              state_d = limit_hit ? ST_RECHECK : ST_READ1;
                else if (op_q && tog_alt)  state_d = ST_SUSP;
                else if (data_bit == exp_q) state_d = ST_DONE;
                else                       state_d = ST_READ1;
            end
            ST_RECHECK: begin
                if (got && rc_q)
                    state_d = (rd_data[POS_TOGGLE] != curr[POS_TOGGLE]) ? ST_RESET_REQ : ST_DONE;
            end
            ST_RESET_REQ: if (cmd_ack) state_d = ST_FAIL;
            ST_WIN_PRE:   if (got) state_d = rd_data[POS_WINDOW] ? ST_WIN_MISS : ST_WIN_CMD;
            ST_WIN_CMD:   if (cmd_ack) state_d = ST_WIN_POST;
            ST_WIN_POST:  if (got) state_d = rd_data[POS_WINDOW] ? ST_WIN_MISS : ST_IDLE;
            ST_DONE, ST_FAIL, ST_SUSP, ST_WIN_MISS: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= 1'b0;
            exp_q   <= 1'b0;
            addr_q  <= '0;
            rc_q    <= 1'b0;
            sec_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rc_q    <= (state_q == ST_RECHECK) ? (rc_q | got) : 1'b0;
            if (state_q == ST_IDLE) begin
                if (start) begin
                    op_q   <= op_erase;
                    exp_q  <= exp_bit;
                    addr_q <= poll_addr;
                    sec_q  <= 1'b0;
                end else if (add_req) begin
                    addr_q <= add_addr;
                end
            end else if (state_q == ST_COMPARE && op_q && tog_main && tog_alt) begin
                sec_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rd_go    = (state_q == ST_READ1) || (state_q == ST_READ2) || (state_q == ST_RECHECK)
                || (state_q == ST_WIN_PRE) || (state_q == ST_WIN_POST);
        cmd_req  = (state_q == ST_RESET_REQ) || (state_q == ST_WIN_CMD);
        cmd_code = (state_q == ST_RESET_REQ) ? CMD_RESET : CMD_ADD;
        cmd_addr = addr_q;
        rd_addr  = addr_q;
        done     = (state_q == ST_DONE);
        fail     = (state_q == ST_FAIL);
        susp     = (state_q == ST_SUSP);
        win_miss = (state_q == ST_WIN_MISS);
        busy     = !((state_q == ST_IDLE) || done || fail || susp || win_miss);
        sec_hit  = sec_q;
    end

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R1
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_code) && $stable(cmd_addr)); // R5
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail, susp, win_miss})); // R3
    AST_DONE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !cmd_req); // R3
    AST_FAIL_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(cmd_req && cmd_ack && cmd_code == CMD_RESET)); // R5
    AST_MISS_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        win_miss |-> $past(rd_ack && rd_data[POS_WINDOW])); // R8
    AST_SUSP_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        susp |-> op_q); // R6
endmodule

// File: tb/sim_flash_poll_ctrl.sv
module sim_flash_poll_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, op_erase = 1'b0, exp_bit = 1'b0, add_req = 1'b0;
    logic [AW-1:0] poll_addr = '0, add_addr = '0;
    logic rd_req, rd_ack = 1'b0, cmd_req, cmd_code, cmd_ack = 1'b0;
    logic [AW-1:0] rd_addr, cmd_addr;
    logic [DW-1:0] rd_data = '0;
    logic busy, done, fail, susp, win_miss, sec_hit;

    always #4 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .exp_bit(exp_bit),
        .poll_addr(poll_addr), .add_req(add_req), .add_addr(add_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .cmd_req(cmd_req), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack),
        .busy(busy), .done(done), .fail(fail), .susp(susp), .win_miss(win_miss),
        .sec_hit(sec_hit)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] scr [0:15];
    int ridx = 0, lat = 0, rwait = 0, cwait = 0, ncmd = 0;
    logic last_code = 1'b0;
    logic [AW-1:0] last_caddr = '0, want_addr = '0;

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // status read responder: acknowledges after lat waiting cycles
    always @(negedge clk) begin
        if (rd_req) begin
            if (rwait < lat) begin
                rwait++;
                rd_ack = 1'b0;
            end else begin
                rwait = 0;
                n_chk++;
                if (rd_addr != want_addr) begin
                    n_bad++;
                    $display("FAIL R1 rd_addr: actual %0d expected %0d", rd_addr, want_addr);
                end
                rd_data = (ridx < 16) ? scr[ridx] : 8'h00;
                ridx++;
                rd_ack = 1'b1;
            end
        end else begin
            rd_ack = 1'b0;
        end
    end

    // command responder
    always @(negedge clk) begin
        if (cmd_req) begin
            if (cwait < lat) begin
                cwait++;
                cmd_ack = 1'b0;
            end else begin
                cwait = 0;
                ncmd++;
                last_code = cmd_code;
                last_caddr = cmd_addr;
                cmd_ack = 1'b1;
            end
        end else begin
            cmd_ack = 1'b0;
        end
    end

    localparam int T_DONE = 0, T_SUSP = 1, T_TOFAIL = 2, T_TOOK = 3, T_MIS = 4;

    // wait for result; returns kind 1 done 2 fail 3 susp 4 miss 0 none
    task automatic wait_end(input bit noise, input logic [AW-1:0] a,
                            output int kind, output bit held);
        kind = 0;
        held = 1'b1;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk); #1;
            if (done | fail | susp | win_miss) begin
                kind = done ? 1 : fail ? 2 : susp ? 3 : 4;
                start = 1'b0; add_req = 1'b0;
                break;
            end
            if (!busy) begin
                if (t == 0) held = 1'b0;
                break;
            end
            if (noise) begin
                start = ~start; add_req = start; poll_addr = ~a; add_addr = ~a;
            end else begin
                start = 1'b0; add_req = 1'b0;
            end
        end
        start = 1'b0; add_req = 1'b0;
    endtask

    task automatic run_poll(input bit op, input bit e, input int k, input int term,
                            input bit m, input int l, input logic [AW-1:0] a,
                            input bit noise, input bit both);
        logic [7:0] x, f, m4;
        int j, kind, ereads, ekind, ecmd;
        bit held;
        string tag;
        x = {~e, 7'b0};
        f = {e, 7'b1000000};
        m4 = m ? 8'h04 : 8'h00;
        j = 0;
        for (int i = 0; i < k; i++) begin
            scr[j] = x; scr[j+1] = x ^ 8'h40 ^ m4; j = j + 2;
        end
        case (term)
            T_DONE:   begin scr[j] = f; scr[j+1] = f; end
            T_SUSP:   begin scr[j] = x; scr[j+1] = x | 8'h04; scr[j+2] = f; scr[j+3] = f; end
            T_TOFAIL: begin scr[j] = x; scr[j+1] = (x ^ 8'h40 ^ m4) | 8'h20;
                            scr[j+2] = x; scr[j+3] = x ^ 8'h40; end
            T_TOOK:   begin scr[j] = x; scr[j+1] = (x ^ 8'h40 ^ m4) | 8'h20;
                            scr[j+2] = x | 8'h20; scr[j+3] = x | 8'h20; end
            default:  begin scr[j] = x; scr[j+1] = x; scr[j+2] = f; scr[j+3] = f; end
        endcase
        ekind  = (term == T_TOFAIL) ? 2 : (term == T_SUSP && op) ? 3 : 1;
        ereads = 2 * k + ((term == T_DONE || (term == T_SUSP && op)) ? 2 : 4);
        ecmd   = (term == T_TOFAIL) ? 1 : 0;
        tag    = (term == T_TOFAIL || term == T_TOOK) ? "R5" : (term == T_SUSP) ? "R6" : "R4";

        @(negedge clk); #1;
        ridx = 0; ncmd = 0; lat = l; rwait = 0; cwait = 0; want_addr = a;
        op_erase = op; exp_bit = e; poll_addr = a; add_addr = ~a;
        start = 1'b1; add_req = both;
        wait_end(noise, a, kind, held);
        check({tag, " result"}, kind, ekind);
        check({tag, " reads"}, ridx, ereads);
        check("R5 commands", ncmd, ecmd);
        if (ecmd == 1) begin
            check("R5 cmd_code", int'(last_code), 1);
            check("R5 cmd_addr", int'(last_caddr), int'(a));
        end
        check("R7 sec_hit", int'(sec_hit), int'(op & m & (k > 0 || term == T_TOFAIL || term == T_TOOK)));
        check("R3 busy held", int'(held), 1);
        if (noise || both) check("R9 ignored/priority reads", ridx, ereads);
        @(negedge clk); #1;
        check("R3 pulse one cycle", int'({done, fail, susp, win_miss, busy}), 0);
    endtask

    task automatic run_win(input logic [AW-1:0] a, input bit pre, input bit post, input int l);
        int kind;
        bit held;
        scr[0] = pre ? 8'h08 : 8'h00;
        scr[1] = post ? 8'h08 : 8'h00;
        @(negedge clk); #1;
        ridx = 0; ncmd = 0; lat = l; rwait = 0; cwait = 0; want_addr = a;
        add_addr = a; poll_addr = ~a; add_req = 1'b1;
        wait_end(1'b0, a, kind, held);
        check("R8 miss", kind, (pre | post) ? 4 : 0);
        check("R8 reads", ridx, pre ? 1 : 2);
        check("R8 commands", ncmd, pre ? 0 : 1);
        if (!pre) begin
            check("R8 cmd_code", int'(last_code), 0);
            check("R8 cmd_addr", int'(last_caddr), int'(a));
        end
        @(negedge clk); #1;
        check("R3 idle after window", int'({done, fail, susp, win_miss, busy}), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int run;
        repeat (3) @(negedge clk);
        #1;
        check("R2 reset outputs",
              int'({busy, rd_req, cmd_req, done, fail, susp, win_miss, sec_hit}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R2 idle after release", int'({busy, rd_req, cmd_req}), 0);
        run = 0;
        for (int op = 0; op < 2; op++)
            for (int e = 0; e < 2; e++)
                for (int k = 0; k < 3; k++)
                    for (int term = 0; term < 5; term++)
                        for (int m = 0; m < 2; m++) begin
                            run_poll(op[0], e[0], k, term, m[0], (k + term) % 3,
                                     run[AW-1:0], (k == 1), e[0]);
                            run++;
                        end
        for (int a = 0; a < 16; a++)
            for (int pp = 0; pp < 4; pp++)
                run_win(a[AW-1:0], pp[1], pp[0], (a + pp) % 3);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule